// File: doc/BRIEF.md
# Descriptor-to-Stream Packetizer

This block turns host-to-card transfer descriptors into packets on an AXI4-Stream output. Descriptors reach it on two valid/ready inputs. The first carries descriptors fetched directly for a queue. The second is a side input on which user logic returns descriptors with an address, a byte length and packet start and end flags. Each queue has a context bit, `qMode`, that the block reads for every descriptor it accepts. A clear bit selects internal handling and a set bit selects bypass handling. The mode decides where tlast falls. With internal handling every descriptor closes its own packet. With bypass handling only the descriptor carrying the end flag closes one, so a single packet can be built from several descriptors.

Each accepted descriptor is cut into 64-bit beats. The block issues one read request per beat, at the descriptor address plus eight bytes per beat. Read data returns in request order on a response port that has no backpressure. The block reserves a buffer slot before it issues each request, so every response has a place to land. The output holds tdata, tkeep and tlast steady while tready is low. When a bypass descriptor breaks the start/end sequence, a sticky error flag is set.

Top module: `desc_stream_packetizer`

## Requirements
- R1: After reset, tvalid, rdReqValid and protoErr are low, and both descriptor inputs show ready.
- R2: A descriptor taken from the direct input always forms one complete packet. tlast is high on its final beat and low on every other beat.
- R3: A descriptor of length L bytes yields max(1, ceil(L/8)) beats. Beat i requests address A+8*i. tdata carries the read responses in the order the requests were issued.
- R4: Every beat except a descriptor's final one has tkeep 8'hFF. The final beat has the low (L mod 8) tkeep bits set, or all eight when L is a nonzero multiple of 8.
- R5: For a queue whose qMode bit is 1, a descriptor on the side input sets tlast only on its final beat, and only if its end flag is set.
- R6: For a queue whose qMode bit is 0, a descriptor on the side input closes its packet on its final beat whatever its flags say, and it never sets protoErr.
- R7: When both inputs are valid and no side-input packet is open, the side input is accepted first. The direct input is never accepted in a cycle in which the side input is valid.
- R8: While a packet started on the side input by a bypass-mode queue is open (start accepted, end not yet accepted), the direct input shows not-ready.
- R9: protoErr is set by a bypass-mode side-input descriptor in two cases: no start flag while no packet is open, or a start flag while a packet is open. Once set, it stays high until reset.
- R10: While tvalid is high and tready is low, tvalid stays high and tdata, tkeep and tlast keep their values on the next cycle.
- R11: Issued read requests whose beats have not yet left the output never exceed DEPTH.
- R12: A zero-length descriptor produces exactly one beat with tkeep 8'h00. That beat is final for the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qMode | input | NUM_Q | Per-queue mode bit, 1 = bypass handling |
| intValid | input | 1 | Direct descriptor valid |
| intReady | output | 1 | Direct descriptor ready |
| intQid | input | QID_W | Direct descriptor queue |
| intAddr | input | ADDR_W | Direct descriptor address |
| intLen | input | LEN_W | Direct descriptor length in bytes |
| bypValid | input | 1 | Side descriptor valid |
| bypReady | output | 1 | Side descriptor ready |
| bypQid | input | QID_W | Side descriptor queue |
| bypAddr | input | ADDR_W | Side descriptor address |
| bypLen | input | LEN_W | Side descriptor length in bytes |
| bypSop | input | 1 | Side descriptor starts a packet |
| bypEop | input | 1 | Side descriptor ends a packet |
| rdReqValid | output | 1 | Beat read request valid |
| rdReqReady | input | 1 | Beat read request accepted |
| rdReqAddr | output | ADDR_W | Beat read address |
| rdRspValid | input | 1 | Read data valid, in request order |
| rdRspData | input | 64 | Read data |
| tvalid | output | 1 | Stream valid |
| tready | input | 1 | Stream ready |
| tdata | output | 64 | Stream data |
| tkeep | output | 8 | Stream byte enables |
| tlast | output | 1 | Stream end of packet |
| protoErr | output | 1 | Sticky side-input sequence error |

## Verification
The bench drives side-input packets of three descriptors whose middle part has a partial length. If tlast were tied to descriptors instead of the queue mode, the packet would be cut early. If tkeep were tied to packet ends, the middle beat would show a full mask where a partial one belongs. Both inputs are raised in the same cycle, and also while a side-input packet is open. A design that arbitrated per descriptor would slip a direct descriptor into the open packet. Long descriptors are run against a stalling sink, a stalling request port and varied response latency. A missing slot reservation would overrun the buffer and lose or reorder beats. A missing output hold would change tdata while it is stalled. Zero-length descriptors and both error conditions are covered, the second one after a reset to show that the flag clears.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int BEAT_BYTES = 8;
  localparam int DATA_W = BEAT_BYTES * 8;
  localparam int OFF_W = $clog2(BEAT_BYTES);

  // Strobe bundle from control to datapath: one slot reserved per issued read
  typedef struct packed {
    logic                  alloc;
    logic                  last;
    logic [BEAT_BYTES-1:0] keep;
  } slotWr_t;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int NUM_Q  = 4,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_Q-1:0]  qMode,
  input  logic              intValid,
  output logic              intReady,
  input  logic [QID_W-1:0]  intQid,
  input  logic [ADDR_W-1:0] intAddr,
  input  logic [LEN_W-1:0]  intLen,
  input  logic              bypValid,
  output logic              bypReady,
  input  logic [QID_W-1:0]  bypQid,
  input  logic [ADDR_W-1:0] bypAddr,
  input  logic [LEN_W-1:0]  bypLen,
  input  logic              bypSop,
  input  logic              bypEop,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [ADDR_W-1:0] rdReqAddr,
  input  logic              slotFree,
  output slotWr_t           wrStb,
  output logic              protoErr
);
  logic                  busy;
  logic [ADDR_W-1:0]     curAddr;
  logic [LEN_W-1:0]      beatsLeft;
  logic [BEAT_BYTES-1:0] tailKeep;
  logic                  closeOnTail;
  logic                  pktOpen;
  logic                  errQ;

  logic                  bypTake, intTake, anyTake;
  logic                  bypModeByp;
  logic [ADDR_W-1:0]     selAddr;
  logic [LEN_W-1:0]      selLen;
  logic                  selClose;
  logic [LEN_W:0]        roundUp;
  logic [LEN_W-1:0]      beatsNew;
  logic [OFF_W-1:0]      rem;
  logic [BEAT_BYTES-1:0] tailNew;
  logic                  onTail, reqFire;

  // Arbitration: the side input wins whenever the engine is idle; the direct
  // input waits while a side-input packet is open so packets never interleave.
  assign bypReady = !busy;
  assign intReady = !busy && !bypValid && !pktOpen;
  assign bypTake  = bypValid && bypReady;
  assign intTake  = intValid && intReady;
  assign anyTake  = bypTake || intTake;

  // Mode is looked up in the queue context for the descriptor being taken
  assign bypModeByp = qMode[bypQid];

  always_comb begin
    if (bypTake) begin
      selAddr  = bypAddr;
      selLen   = bypLen;
      selClose = !bypModeByp || bypEop;
    end else begin
      selAddr  = intAddr;
      selLen   = intLen;
      selClose = 1'b1;
    end
  end

  // Beat count and final-beat byte mask derived from the byte length
  assign roundUp  = {1'b0, selLen} + (LEN_W+1)'(BEAT_BYTES - 1);
  assign beatsNew = (selLen == '0) ? LEN_W'(1) : LEN_W'(roundUp >> OFF_W);
  assign rem      = selLen[OFF_W-1:0];

  always_comb begin
    if (selLen == '0)
      tailNew = '0;
    else if (rem == '0)
      tailNew = '1;
    else
      tailNew = BEAT_BYTES'((32'd1 << rem) - 32'd1);
  end

  // Request issue: one beat per request, only when a buffer slot is free
  assign rdReqValid = busy && slotFree;
  assign rdReqAddr  = curAddr;
  assign reqFire    = rdReqValid && rdReqReady;
  assign onTail     = (beatsLeft == LEN_W'(1));

  assign wrStb.alloc = reqFire;
  assign wrStb.keep  = onTail ? tailKeep : '1;
  assign wrStb.last  = onTail && closeOnTail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      curAddr     <= '0;
      beatsLeft   <= '0;
      tailKeep    <= '0;
      closeOnTail <= 1'b0;
    end else if (anyTake) begin
      busy        <= 1'b1;
      curAddr     <= selAddr;
      beatsLeft   <= beatsNew;
      tailKeep    <= tailNew;
      closeOnTail <= selClose;
    end else if (reqFire) begin
      curAddr   <= curAddr + ADDR_W'(BEAT_BYTES);
      beatsLeft <= beatsLeft - LEN_W'(1);
      if (onTail) busy <= 1'b0;
    end
  end

  // Packet framing tracker and sticky sequence error for bypass-mode queues
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktOpen <= 1'b0;
      errQ    <= 1'b0;
    end else if (bypTake && bypModeByp) begin
      pktOpen <= !bypEop;
      if (bypSop == pktOpen) errQ <= 1'b1;
    end
  end

  assign protoErr = errQ;
endmodule

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  slotWr_t               wrStb,
  output logic                  slotFree,
  input  logic                  rspValid,
  input  logic [DATA_W-1:0]     rspData,
  output logic                  tvalid,
  input  logic                  tready,
  output logic [DATA_W-1:0]     tdata,
  output logic [BEAT_BYTES-1:0] tkeep,
  output logic                  tlast
);
  logic [PTR_W-1:0] allocPtr, fillPtr, popPtr;
  logic [CNT_W-1:0] used, pendCnt;
  logic             fillOk, pop;

  logic [DEPTH-1:0]      filledVec;
  logic [DATA_W-1:0]     dataArr [DEPTH];
  logic [BEAT_BYTES-1:0] keepArr [DEPTH];
  logic                  lastArr [DEPTH];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign fillOk   = rspValid && (pendCnt != '0);
  assign pop      = tvalid && tready;
  assign slotFree = (used < CNT_W'(DEPTH));

  // Ring of slots: reserved at request time, filled in order by responses,
  // drained in order by the stream output
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [DATA_W-1:0]     dataR;
    logic [BEAT_BYTES-1:0] keepR;
    logic                  lastR;
    logic                  fullR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fullR <= 1'b0;
      else if (fillOk && fillPtr == PTR_W'(g))
        fullR <= 1'b1;
      else if (pop && popPtr == PTR_W'(g))
        fullR <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wrStb.alloc && allocPtr == PTR_W'(g)) begin
        keepR <= wrStb.keep;
        lastR <= wrStb.last;
      end
      if (fillOk && fillPtr == PTR_W'(g))
        dataR <= rspData;
    end

    assign filledVec[g] = fullR;
    assign dataArr[g]   = dataR;
    assign keepArr[g]   = keepR;
    assign lastArr[g]   = lastR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocPtr <= '0;
      fillPtr  <= '0;
      popPtr   <= '0;
      used     <= '0;
      pendCnt  <= '0;
    end else begin
      if (wrStb.alloc) allocPtr <= nextPtr(allocPtr);
      if (fillOk)      fillPtr  <= nextPtr(fillPtr);
      if (pop)         popPtr   <= nextPtr(popPtr);
      used    <= used + CNT_W'(wrStb.alloc) - CNT_W'(pop);
      pendCnt <= pendCnt + CNT_W'(wrStb.alloc) - CNT_W'(fillOk);
    end
  end

  assign tvalid = filledVec[popPtr];
  assign tdata  = dataArr[popPtr];
  assign tkeep  = keepArr[popPtr];
  assign tlast  = lastArr[popPtr];
endmodule

// File: rtl/desc_stream_packetizer.sv
module desc_stream_packetizer
  import dsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 4,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_Q-1:0]      qMode,
  input  logic                  intValid,
  output logic                  intReady,
  input  logic [QID_W-1:0]      intQid,
  input  logic [ADDR_W-1:0]     intAddr,
  input  logic [LEN_W-1:0]      intLen,
  input  logic                  bypValid,
  output logic                  bypReady,
  input  logic [QID_W-1:0]      bypQid,
  input  logic [ADDR_W-1:0]     bypAddr,
  input  logic [LEN_W-1:0]      bypLen,
  input  logic                  bypSop,
  input  logic                  bypEop,
  output logic                  rdReqValid,
  input  logic                  rdReqReady,
  output logic [ADDR_W-1:0]     rdReqAddr,
  input  logic                  rdRspValid,
  input  logic [DATA_W-1:0]     rdRspData,
  output logic                  tvalid,
  input  logic                  tready,
  output logic [DATA_W-1:0]     tdata,
  output logic [BEAT_BYTES-1:0] tkeep,
  output logic                  tlast,
  output logic                  protoErr
);
  slotWr_t wrStb;
  logic    slotFree;

  dsp_ctrl #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .NUM_Q (NUM_Q)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .qMode     (qMode),
    .intValid  (intValid),
    .intReady  (intReady),
    .intQid    (intQid),
    .intAddr   (intAddr),
    .intLen    (intLen),
    .bypValid  (bypValid),
    .bypReady  (bypReady),
    .bypQid    (bypQid),
    .bypAddr   (bypAddr),
    .bypLen    (bypLen),
    .bypSop    (bypSop),
    .bypEop    (bypEop),
    .rdReqValid(rdReqValid),
    .rdReqReady(rdReqReady),
    .rdReqAddr (rdReqAddr),
    .slotFree  (slotFree),
    .wrStb     (wrStb),
    .protoErr  (protoErr)
  );

  dsp_datapath #(
    .DEPTH(DEPTH)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .slotFree(slotFree),
    .rspValid(rdRspValid),
    .rspData (rdRspData),
    .tvalid  (tvalid),
    .tready  (tready),
    .tdata   (tdata),
    .tkeep   (tkeep),
    .tlast   (tlast)
  );
endmodule

// File: rtl/dsp_chk.sv
module dsp_chk #(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 4,
  parameter int QID_W  = 2,
  parameter int KEEP_W = 8,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_Q-1:0]  qMode,
  input logic              intValid,
  input logic              intReady,
  input logic              bypValid,
  input logic              bypReady,
  input logic [QID_W-1:0]  bypQid,
  input logic              bypEop,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic              tvalid,
  input logic              tready,
  input logic [DATA_W-1:0] tdata,
  input logic [KEEP_W-1:0] tkeep,
  input logic              tlast,
  input logic              protoErr
);
  logic        openMirror;
  logic [15:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openMirror <= 1'b0;
      inFlight   <= '0;
    end else begin
      if (bypValid && bypReady && qMode[bypQid]) openMirror <= !bypEop;
      inFlight <= inFlight + 16'(rdReqValid && rdReqReady) - 16'(tvalid && tready);
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R7
  side_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    intValid && intReady |-> !bypValid);

  // R8
  open_blocks_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    openMirror |-> !intReady);

  // R11
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 16'(DEPTH));
endmodule

bind desc_stream_packetizer dsp_chk #(
  .NUM_Q (NUM_Q),
  .DEPTH (DEPTH),
  .QID_W (QID_W),
  .KEEP_W(dsp_pkg::BEAT_BYTES),
  .DATA_W(dsp_pkg::DATA_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .qMode     (qMode),
  .intValid  (intValid),
  .intReady  (intReady),
  .bypValid  (bypValid),
  .bypReady  (bypReady),
  .bypQid    (bypQid),
  .bypEop    (bypEop),
  .rdReqValid(rdReqValid),
  .rdReqReady(rdReqReady),
  .tvalid    (tvalid),
  .tready    (tready),
  .tdata     (tdata),
  .tkeep     (tkeep),
  .tlast     (tlast),
  .protoErr  (protoErr)
);

// File: tb/sim_desc_stream_packetizer.sv
module sim_desc_stream_packetizer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int NUM_Q  = 4;
  localparam int DEPTH  = 4;
  localparam int QID_W  = 2;

  logic              clk, rstN;
  logic [NUM_Q-1:0]  qMode;
  logic              intValid, intReady;
  logic [QID_W-1:0]  intQid;
  logic [ADDR_W-1:0] intAddr;
  logic [LEN_W-1:0]  intLen;
  logic              bypValid, bypReady;
  logic [QID_W-1:0]  bypQid;
  logic [ADDR_W-1:0] bypAddr;
  logic [LEN_W-1:0]  bypLen;
  logic              bypSop, bypEop;
  logic              rdReqValid, rdReqReady;
  logic [ADDR_W-1:0] rdReqAddr;
  logic              rdRspValid;
  logic [63:0]       rdRspData;
  logic              tvalid, tready;
  logic [63:0]       tdata;
  logic [7:0]        tkeep;
  logic              tlast;
  logic              protoErr;

  desc_stream_packetizer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_Q(NUM_Q), .DEPTH(DEPTH)
  ) u0 (
    .clk(clk), .rstN(rstN), .qMode(qMode),
    .intValid(intValid), .intReady(intReady), .intQid(intQid),
    .intAddr(intAddr), .intLen(intLen),
    .bypValid(bypValid), .bypReady(bypReady), .bypQid(bypQid),
    .bypAddr(bypAddr), .bypLen(bypLen), .bypSop(bypSop), .bypEop(bypEop),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdRspValid(rdRspValid), .rdRspData(rdRspData),
    .tvalid(tvalid), .tready(tready), .tdata(tdata), .tkeep(tkeep),
    .tlast(tlast), .protoErr(protoErr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int checks = 0;
  int bad = 0;

  function automatic void check(bit ok, string req, string what,
                                logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  function automatic logic [63:0] patt(input logic [31:0] a);
    return {a ^ 32'h5A3C_96E1, a};
  endfunction

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  keep;
    logic        last;
    string       tag;
  } beat_t;

  beat_t       expQ[$];
  logic [31:0] reqQ[$];
  logic [31:0] rspAddrQ[$];
  int          rspDueQ[$];
  int          outstanding = 0;
  int          cyc = 0;
  int          lastDue = 0;
  int          lastBypAcc = 0;
  int          lastIntAcc = 0;
  bit          mOpen = 0;
  bit          mErr = 0;
  bit          stress = 0;
  bit          haveSnap = 0;

  // snapshot of all port values as they stand before the coming clock edge
  logic        sIntV, sIntR, sBypV, sBypR, sBypSop, sBypEop, sReqV, sReqR;
  logic        sTv, sTr, sTl, sErr;
  logic [1:0]  sIntQ, sBypQ;
  logic [31:0] sIntA, sBypA, sReqA;
  logic [15:0] sIntL, sBypL;
  logic [63:0] sTd;
  logic [7:0]  sTk;

  function automatic void pushDesc(logic [31:0] a, int len, bit closes, string tag);
    int n = (len == 0) ? 1 : (len + 7) / 8;
    for (int i = 0; i < n; i++) begin
      beat_t b;
      b.addr = a + 32'(8 * i);
      if (i != n - 1)        b.keep = 8'hFF;
      else if (len == 0)     b.keep = 8'h00;
      else if (len % 8 == 0) b.keep = 8'hFF;
      else                   b.keep = 8'((1 << (len % 8)) - 1);
      b.last = (i == n - 1) && closes;
      b.tag  = (len == 0) ? "R12" : tag;
      expQ.push_back(b);
      reqQ.push_back(b.addr);
    end
  endfunction

  task automatic processSnap();
    if (sIntV && sIntR) begin
      check(!sBypV, "R7", "direct taken while side valid", 64'(sBypV), 64'd0);
      check(!mOpen, "R8", "direct taken inside open packet", 64'(mOpen), 64'd0);
      pushDesc(sIntA, int'(sIntL), 1'b1, "R2");
      lastIntAcc = cyc;
    end
    if (sBypV && sBypR) begin
      if (qMode[sBypQ]) begin
        if (sBypSop == mOpen) mErr = 1'b1;
        mOpen = !sBypEop;
        pushDesc(sBypA, int'(sBypL), sBypEop, "R5");
      end else begin
        pushDesc(sBypA, int'(sBypL), 1'b1, "R6");
      end
      lastBypAcc = cyc;
    end
    if (sReqV && sReqR) begin
      int due;
      logic [31:0] ea = (reqQ.size() > 0) ? reqQ.pop_front() : 32'hFFFF_FFFF;
      check(sReqA == ea, "R3", "request address", 64'(sReqA), 64'(ea));
      due = cyc + (stress ? 1 + cyc % 3 : 2);
      if (due < lastDue) due = lastDue;
      lastDue = due;
      rspAddrQ.push_back(sReqA);
      rspDueQ.push_back(due);
      outstanding++;
      check(outstanding <= DEPTH, "R11", "beats in flight", 64'(outstanding), 64'(DEPTH));
    end
    if (sTv && sTr) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected beat", sTd, 64'd0);
      end else begin
        beat_t b = expQ.pop_front();
        check(sTd == patt(b.addr), "R3", "tdata", sTd, patt(b.addr));
        check(sTk == b.keep, (b.tag == "R12") ? "R12" : "R4", "tkeep", 64'(sTk), 64'(b.keep));
        check(sTl == b.last, b.tag, "tlast", 64'(sTl), 64'(b.last));
      end
      outstanding--;
    end
  endtask

  // Monitor, reference model and read responder
  initial begin
    rdRspValid = 1'b0;
    rdRspData  = '0;
    tready     = 1'b1;
    rdReqReady = 1'b1;
    forever begin
      logic pTv, pTr, pTl;
      logic [63:0] pTd;
      logic [7:0] pTk;
      @(negedge clk);
      #1;
      cyc++;
      if (!rstN) begin
        expQ.delete(); reqQ.delete(); rspAddrQ.delete(); rspDueQ.delete();
        outstanding = 0; mOpen = 0; mErr = 0; haveSnap = 0; lastDue = 0;
        rdRspValid = 1'b0;
      end else begin
        if (haveSnap) processSnap();
        tready     = stress ? (cyc % 3 != 0) : 1'b1;
        rdReqReady = stress ? (cyc % 4 != 1) : 1'b1;
        if (rspDueQ.size() > 0 && rspDueQ[0] <= cyc) begin
          void'(rspDueQ.pop_front());
          rdRspData  = patt(rspAddrQ.pop_front());
          rdRspValid = 1'b1;
        end else begin
          rdRspValid = 1'b0;
        end
      end
      #1;
      pTv = sTv; pTr = sTr; pTd = sTd; pTk = sTk; pTl = sTl;
      sIntV = intValid; sIntR = intReady; sIntQ = intQid; sIntA = intAddr; sIntL = intLen;
      sBypV = bypValid; sBypR = bypReady; sBypQ = bypQid; sBypA = bypAddr; sBypL = bypLen;
      sBypSop = bypSop; sBypEop = bypEop;
      sReqV = rdReqValid; sReqR = rdReqReady; sReqA = rdReqAddr;
      sTv = tvalid; sTr = tready; sTd = tdata; sTk = tkeep; sTl = tlast; sErr = protoErr;
      if (rstN) begin
        if (haveSnap && pTv && !pTr) begin
          check(sTv == 1'b1, "R10", "tvalid dropped under stall", 64'(sTv), 64'd1);
          check(sTd == pTd && sTk == pTk && sTl == pTl, "R10", "beat changed under stall",
                sTd, pTd);
        end
        check(sErr == mErr, "R9", "protoErr", 64'(sErr), 64'(mErr));
        if (mOpen) check(!intReady, "R8", "direct ready inside open packet", 64'(intReady), 64'd0);
        if (sIntV && sBypV && !mOpen && sBypR)
          check(!sIntR, "R7", "direct ready while side valid", 64'(sIntR), 64'd0);
      end
      haveSnap = rstN;
    end
  end

  task automatic sendInt(input logic [1:0] q, input logic [31:0] a, input int len);
    bit acc;
    @(negedge clk);
    intQid = q; intAddr = a; intLen = 16'(len); intValid = 1'b1;
    forever begin
      #3;
      acc = intReady;
      @(negedge clk);
      if (acc) break;
    end
    intValid = 1'b0;
  endtask

  task automatic sendByp(input logic [1:0] q, input logic [31:0] a, input int len,
                         input bit sop, input bit eop);
    bit acc;
    @(negedge clk);
    bypQid = q; bypAddr = a; bypLen = 16'(len); bypSop = sop; bypEop = eop; bypValid = 1'b1;
    forever begin
      #3;
      acc = bypReady;
      @(negedge clk);
      if (acc) break;
    end
    bypValid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    repeat (2) @(negedge clk);
    while ((expQ.size() > 0 || outstanding > 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(expQ.size() == 0, "R3", "beats left undelivered", 64'(expQ.size()), 64'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL R3 watchdog expired actual=%0d expected=0", expQ.size());
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    qMode = 4'b1100;
    intValid = 0; intQid = '0; intAddr = '0; intLen = '0;
    bypValid = 0; bypQid = '0; bypAddr = '0; bypLen = '0; bypSop = 0; bypEop = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    // R1 reset state
    check(tvalid == 1'b0, "R1", "tvalid", 64'(tvalid), 64'd0);
    check(rdReqValid == 1'b0, "R1", "rdReqValid", 64'(rdReqValid), 64'd0);
    check(protoErr == 1'b0, "R1", "protoErr", 64'(protoErr), 64'd0);
    check(intReady && bypReady, "R1", "input ready", 64'({intReady, bypReady}), 64'h3);

    // R2 R4: direct descriptors, partial, exact and single-byte lengths
    sendInt(2'd0, 32'h1000, 20);
    sendInt(2'd1, 32'h2000, 16);
    sendInt(2'd0, 32'h3000, 1);
    drain();

    // R5: three side descriptors forming one packet, partial middle part
    sendByp(2'd2, 32'h4000, 8, 1, 0);
    sendByp(2'd2, 32'h5000, 13, 0, 0);
    sendByp(2'd2, 32'h6000, 24, 0, 1);
    drain();

    // R6: internal-mode queue on the side input ignores its flags
    sendByp(2'd1, 32'h7000, 9, 0, 0);
    sendByp(2'd0, 32'h7100, 3, 1, 1);
    drain();
    check(protoErr == 1'b0, "R6", "protoErr after internal-mode side input", 64'(protoErr), 64'd0);

    // R7: both inputs valid together
    fork
      sendByp(2'd3, 32'h8000, 16, 1, 1);
      sendInt(2'd0, 32'h9000, 8);
    join
    drain();
    check(lastBypAcc < lastIntAcc, "R7", "side accepted first", 64'(lastBypAcc), 64'(lastIntAcc));

    // R8: direct descriptor held off while a side packet is open
    fork
      begin
        sendByp(2'd2, 32'hA000, 8, 1, 0);
        repeat (8) @(negedge clk);
        sendByp(2'd2, 32'hA100, 8, 0, 1);
      end
      sendInt(2'd1, 32'hB000, 8);
    join
    drain();
    check(lastIntAcc > lastBypAcc, "R8", "direct after packet end", 64'(lastIntAcc), 64'(lastBypAcc));

    // R12: zero-length descriptor
    sendInt(2'd0, 32'hC000, 0);
    drain();

    // R10 R11: stalls on all sides, long descriptors
    stress = 1'b1;
    for (int i = 0; i < 5; i++)
      sendInt(2'(i % 2), 32'hD000 + 32'(256 * i), 5 + 23 * i);
    sendByp(2'd3, 32'hE000, 100, 1, 0);
    sendByp(2'd3, 32'hE400, 7, 0, 0);
    sendByp(2'd3, 32'hE800, 40, 0, 1);
    drain();
    stress = 1'b0;

    // R9: missing start while closed, then stickiness, then reset, then start while open
    sendByp(2'd2, 32'hF000, 8, 0, 1);
    drain();
    check(protoErr == 1'b1, "R9", "missing start", 64'(protoErr), 64'd1);
    sendByp(2'd2, 32'hF100, 8, 1, 1);
    drain();
    check(protoErr == 1'b1, "R9", "flag sticky", 64'(protoErr), 64'd1);
    doReset();
    @(negedge clk);
    #3;
    check(protoErr == 1'b0, "R9", "cleared by reset", 64'(protoErr), 64'd0);
    sendByp(2'd3, 32'hF200, 8, 1, 0);
    sendByp(2'd3, 32'hF300, 8, 1, 1);
    drain();
    check(protoErr == 1'b1, "R9", "start inside open packet", 64'(protoErr), 64'd1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule